// File: doc/BRIEF.md
# Core Light-Sleep Entry and Wake Controller

This block decides when the processor core clock is stopped for light sleep and when it is released again. Only the core clock is gated; bus and peripheral clocks are not touched here. Sleep is requested by the pulse of a wait-for-interrupt or wait-for-event instruction, or, when the sleep-on-exit control is set, by the return from the last exception handler. A set deep-sleep select refuses light-sleep entry entirely.

The instruction that caused entry is latched as a one-bit cause and selects the wake rule. Interrupt-wait sleep ends on any pending interrupt. Event-wait sleep ends on any wakeup event, and also on a pending interrupt when send-event-on-pending is set. Wakeup restarts the core clock on the very next clock edge with no added wait state, and a one-cycle pulse reports whether an interrupt or an event ended the sleep. A wake source that is already active in the cycle of an entry request cancels that entry, so the clock is never gated for it.

Top module: `core_sleep_ctrl`

## Requirements
- R1: After reset, core_clk_en_o is 1, sleeping_o is 0, and wake_irq_o and wake_evt_o are both 0.
- R2: While deep_sel_i is 1, no instruction pulse and no exception return puts the block to sleep.
- R3: With deep_sel_i and sleep_on_exit_i both 0, a wfi_exec_i or wfe_exec_i pulse with no cancelling wake source makes core_clk_en_o 0 and sleeping_o 1 from the next clock edge; if both pulse in the same cycle, the interrupt-wait rule applies.
- R4: In interrupt-wait sleep, any set bit of irq_pend_i wakes the core: at the next edge core_clk_en_o is 1, sleeping_o is 0 and wake_irq_o is 1; wake events alone do not wake it.
- R5: In event-wait sleep with sev_on_pend_i 0, pending interrupts are ignored, and any set bit of wake_evt_i wakes the core with wake_evt_o 1 at the next edge.
- R6: In event-wait sleep with sev_on_pend_i 1, a pending interrupt also wakes the core; when an interrupt causes the wake (alone or together with an event) wake_irq_o is reported, not wake_evt_o.
- R7: With sleep_on_exit_i 1, instruction pulses do not cause entry; an exc_return_i pulse with no bit of irq_pend_i set enters interrupt-wait sleep at the next edge, and one with an interrupt pending does not.
- R8: A wake source that satisfies the rule of the requested cause in the same cycle as the entry request cancels entry: the core clock stays enabled and no wake cause pulses.
- R9: The latched cause is cleared on wakeup, so a following interrupt-wait sleep is not woken by events.
- R10: wake_irq_o and wake_evt_o are never 1 together, each is high for exactly one cycle per wakeup, and neither is high while sleeping_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_exec_i | input | 1 | One-cycle pulse: wait-for-interrupt executed |
| wfe_exec_i | input | 1 | One-cycle pulse: wait-for-event executed |
| deep_sel_i | input | 1 | Deep-sleep selected; refuses light-sleep entry |
| sleep_on_exit_i | input | 1 | Sleep on return from last handler instead of on the instruction |
| sev_on_pend_i | input | 1 | Lets pending interrupts wake event-wait sleep |
| irq_pend_i | input | N_IRQ | Pending interrupt lines |
| wake_evt_i | input | N_EVT | Wakeup event lines |
| exc_return_i | input | 1 | One-cycle pulse: exception return completed |
| core_clk_en_o | output | 1 | Core clock enable, registered |
| sleeping_o | output | 1 | Core is in light sleep |
| wake_irq_o | output | 1 | One-cycle pulse: an interrupt ended the sleep |
| wake_evt_o | output | 1 | One-cycle pulse: an event ended the sleep |

## Verification
Entry and wakeup can fall in the same cycle: an instruction pulse or exception return arrives while a wake source valid for the requested cause is already present. The bench provokes this by raising an interrupt line together with a wfi pulse, an event line together with a wfe pulse, and an interrupt together with a wfe pulse under send-event-on-pending, then judges that the core clock enable never drops and no wake cause pulses. It also applies an interrupt together with wfe while send-event-on-pending is clear, where entry must go ahead.

// File: rtl/core_sleep_pkg.sv
package core_sleep_pkg;
   typedef enum logic {ST_RUN = 1'b0, ST_SLEEP = 1'b1} sleep_state_e;
   typedef enum logic {CAUSE_IRQ = 1'b0, CAUSE_EVT = 1'b1} sleep_cause_e;
endpackage

// File: rtl/core_sleep_wake.sv
// Evaluates the wake rule for one given entry cause.
module core_sleep_wake
   import core_sleep_pkg::*;
#(
   parameter bit EVT_ON_PEND_EN = 1'b1
) (
   input  sleep_cause_e cause_i,
   input  logic         any_irq_i,
   input  logic         any_evt_i,
   input  logic         sev_pend_i,
   output logic         wake_o,
   output logic         by_irq_o
);
   logic irq_allowed;

   generate
      if (EVT_ON_PEND_EN) begin : g_pend_wakes_evt
         assign irq_allowed = (cause_i == CAUSE_IRQ) | sev_pend_i;
      end else begin : g_pend_fixed
         logic unused_sev;
         assign unused_sev  = sev_pend_i;
         assign irq_allowed = (cause_i == CAUSE_IRQ);
      end
   endgenerate

   assign by_irq_o = irq_allowed & any_irq_i;
   assign wake_o   = by_irq_o | ((cause_i == CAUSE_EVT) & any_evt_i);
endmodule

// File: rtl/core_sleep_entry.sv
// Decides whether an entry is requested this cycle and with which cause.
module core_sleep_entry
   import core_sleep_pkg::*;
(
   input  logic         wfi_i,
   input  logic         wfe_i,
   input  logic         deep_sel_i,
   input  logic         on_exit_i,
   input  logic         exc_ret_i,
   input  logic         any_irq_i,
   output logic         req_o,
   output sleep_cause_e cause_o
);
   logic instr_req;
   logic exit_req;

   assign instr_req = ~on_exit_i & (wfi_i | wfe_i);
   assign exit_req  = on_exit_i & exc_ret_i & ~any_irq_i;
   assign req_o     = ~deep_sel_i & (instr_req | exit_req);

   always_comb begin
      if (on_exit_i || wfi_i) cause_o = CAUSE_IRQ;
      else                    cause_o = CAUSE_EVT;
   end
endmodule

// File: rtl/core_sleep_fsm.sv
// Registered run/sleep state, latched cause and wake pulses.
module core_sleep_fsm
   import core_sleep_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enter_i,
   input  sleep_cause_e enter_cause_i,
   input  logic         wake_i,
   input  logic         wake_by_irq_i,
   output sleep_state_e state_o,
   output sleep_cause_e cause_o,
   output logic         clk_en_o,
   output logic         wake_irq_o,
   output logic         wake_evt_o
);
   sleep_state_e state_q, state_d;
   sleep_cause_e cause_q, cause_d;
   logic         wirq_d, wevt_d;

   always_comb begin
      state_d = state_q;
      cause_d = cause_q;
      wirq_d  = 1'b0;
      wevt_d  = 1'b0;
      unique case (state_q)
         ST_RUN: begin
            if (enter_i) begin
               state_d = ST_SLEEP;
               cause_d = enter_cause_i;
            end
         end
         ST_SLEEP: begin
            if (wake_i) begin
               state_d = ST_RUN;
               cause_d = CAUSE_IRQ;
               wirq_d  = wake_by_irq_i;
               wevt_d  = ~wake_by_irq_i;
            end
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_RUN;
         cause_q    <= CAUSE_IRQ;
         clk_en_o   <= 1'b1;
         wake_irq_o <= 1'b0;
         wake_evt_o <= 1'b0;
      end else begin
         state_q    <= state_d;
         cause_q    <= cause_d;
         clk_en_o   <= (state_d == ST_RUN);
         wake_irq_o <= wirq_d;
         wake_evt_o <= wevt_d;
      end
   end

   assign state_o = state_q;
   assign cause_o = cause_q;
endmodule

// File: rtl/core_sleep_ctrl.sv
module core_sleep_ctrl
   import core_sleep_pkg::*;
#(
   parameter int unsigned N_IRQ          = 16,
   parameter int unsigned N_EVT          = 4,
   parameter bit          EVT_ON_PEND_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wfi_exec_i,
   input  logic             wfe_exec_i,
   input  logic             deep_sel_i,
   input  logic             sleep_on_exit_i,
   input  logic             sev_on_pend_i,
   input  logic [N_IRQ-1:0] irq_pend_i,
   input  logic [N_EVT-1:0] wake_evt_i,
   input  logic             exc_return_i,
   output logic             core_clk_en_o,
   output logic             sleeping_o,
   output logic             wake_irq_o,
   output logic             wake_evt_o
);
   generate
      if (N_IRQ < 1) begin : g_bad_irq
         $error("core_sleep_ctrl: N_IRQ must be at least 1");
      end
      if (N_EVT < 1) begin : g_bad_evt
         $error("core_sleep_ctrl: N_EVT must be at least 1");
      end
   endgenerate

   logic         any_irq, any_evt;
   logic         entry_req, entry_cancel, entry_by_irq;
   sleep_cause_e entry_cause, cause_q;
   logic         sleep_wake, sleep_by_irq;
   sleep_state_e state;

   assign any_irq = |irq_pend_i;
   assign any_evt = |wake_evt_i;

   core_sleep_entry u_entry (
      .wfi_i      (wfi_exec_i),
      .wfe_i      (wfe_exec_i),
      .deep_sel_i (deep_sel_i),
      .on_exit_i  (sleep_on_exit_i),
      .exc_ret_i  (exc_return_i),
      .any_irq_i  (any_irq),
      .req_o      (entry_req),
      .cause_o    (entry_cause)
   );

   // Rule of the requested cause, used to cancel entry.
   core_sleep_wake #(.EVT_ON_PEND_EN(EVT_ON_PEND_EN)) u_wake_entry (
      .cause_i    (entry_cause),
      .any_irq_i  (any_irq),
      .any_evt_i  (any_evt),
      .sev_pend_i (sev_on_pend_i),
      .wake_o     (entry_cancel),
      .by_irq_o   (entry_by_irq)
   );

   // Rule of the latched cause, used while asleep.
   core_sleep_wake #(.EVT_ON_PEND_EN(EVT_ON_PEND_EN)) u_wake_sleep (
      .cause_i    (cause_q),
      .any_irq_i  (any_irq),
      .any_evt_i  (any_evt),
      .sev_pend_i (sev_on_pend_i),
      .wake_o     (sleep_wake),
      .by_irq_o   (sleep_by_irq)
   );

   logic unused_entry_by_irq;
   assign unused_entry_by_irq = entry_by_irq;

   core_sleep_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .enter_i       (entry_req & ~entry_cancel),
      .enter_cause_i (entry_cause),
      .wake_i        (sleep_wake),
      .wake_by_irq_i (sleep_by_irq),
      .state_o       (state),
      .cause_o       (cause_q),
      .clk_en_o      (core_clk_en_o),
      .wake_irq_o    (wake_irq_o),
      .wake_evt_o    (wake_evt_o)
   );

   assign sleeping_o = (state == ST_SLEEP);
endmodule

// File: rtl/core_sleep_ctrl_chk.sv
module core_sleep_ctrl_chk #(
   parameter int unsigned N_IRQ = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wfi_exec_i,
   input logic             deep_sel_i,
   input logic             sleep_on_exit_i,
   input logic             exc_return_i,
   input logic [N_IRQ-1:0] irq_pend_i,
   input logic             core_clk_en_o,
   input logic             sleeping_o,
   input logic             wake_irq_o,
   input logic             wake_evt_o,
   input logic             cause_q
);
   // R2: deep-sleep select keeps the core running
   assert_deep_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleeping_o && deep_sel_i) |=> !sleeping_o && core_clk_en_o);

   // R3: wfi with no pending interrupt enters sleep at the next edge
   assert_wfi_enters_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleeping_o && wfi_exec_i && !deep_sel_i && !sleep_on_exit_i && (irq_pend_i == '0))
      |=> sleeping_o && !core_clk_en_o);

   // R4: interrupt-wait sleep ends on any pending interrupt
   assert_irq_wakes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sleeping_o && (cause_q == 1'b0) && (irq_pend_i != '0))
      |=> !sleeping_o && core_clk_en_o && wake_irq_o);

   // R7: on-exit mode without exception return never starts sleep
   assert_exit_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleeping_o && sleep_on_exit_i && !exc_return_i) |=> !sleeping_o);

   // R10: causes exclusive, single-cycle, only right after sleeping
   assert_cause_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wake_irq_o, wake_evt_o}));
   assert_cause_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_irq_o || wake_evt_o) |=> !wake_irq_o && !wake_evt_o);
   assert_cause_after_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_irq_o || wake_evt_o) |-> !sleeping_o && $past(sleeping_o));
endmodule

bind core_sleep_ctrl core_sleep_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .wfi_exec_i      (wfi_exec_i),
   .deep_sel_i      (deep_sel_i),
   .sleep_on_exit_i (sleep_on_exit_i),
   .exc_return_i    (exc_return_i),
   .irq_pend_i      (irq_pend_i),
   .core_clk_en_o   (core_clk_en_o),
   .sleeping_o      (sleeping_o),
   .wake_irq_o      (wake_irq_o),
   .wake_evt_o      (wake_evt_o),
   .cause_q         (cause_q)
);

// File: tb/test_core_sleep_ctrl.sv
`timescale 1ns/1ps
module test_core_sleep_ctrl;
   localparam int NI = 16;
   localparam int NE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wfi = 0, wfe = 0, deep = 0, soe = 0, sevp = 0, excr = 0;
   logic [NI-1:0] irq = '0;
   logic [NE-1:0] evt = '0;
   logic clk_en, slp, wirq, wevt;
   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   core_sleep_ctrl #(.N_IRQ(NI), .N_EVT(NE)) i_core_sleep_ctrl (
      .clk(clk), .rst_n(rst_n), .wfi_exec_i(wfi), .wfe_exec_i(wfe),
      .deep_sel_i(deep), .sleep_on_exit_i(soe), .sev_on_pend_i(sevp),
      .irq_pend_i(irq), .wake_evt_i(evt), .exc_return_i(excr),
      .core_clk_en_o(clk_en), .sleeping_o(slp),
      .wake_irq_o(wirq), .wake_evt_o(wevt));

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: {clk_en,sleeping,wake_irq,wake_evt} actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic [3:0] outs();
      return {clk_en, slp, wirq, wevt};
   endfunction

   // Inputs change at negedge; one tick passes a posedge and lands on the next negedge.
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle_all();
      wfi = 0; wfe = 0; excr = 0; irq = '0; evt = '0;
   endtask

   task automatic go_sleep_wfi();
      wfi = 1; tick(); wfi = 0;
   endtask

   task automatic go_sleep_wfe();
      wfe = 1; tick(); wfe = 0;
   endtask

   task automatic t_reset();
      chk("R1 reset", outs(), 4'b1000);
   endtask

   task automatic t_deep();
      deep = 1;
      go_sleep_wfi(); chk("R2 wfi with deep", outs(), 4'b1000);
      go_sleep_wfe(); chk("R2 wfe with deep", outs(), 4'b1000);
      soe = 1; excr = 1; tick(); excr = 0; soe = 0;
      chk("R2 exit with deep", outs(), 4'b1000);
      deep = 0; tick();
   endtask

   task automatic t_wfi();
      go_sleep_wfi(); chk("R3 wfi enters", outs(), 4'b0100);
      evt = 4'b0010; tick(); evt = '0;
      chk("R4 event ignored in wfi sleep", outs(), 4'b0100);
      irq = 16'h0400; tick(); irq = '0;
      chk("R4 irq wakes", outs(), 4'b1010);
      tick(); chk("R10 pulse one cycle", outs(), 4'b1000);
   endtask

   task automatic t_wfe();
      sevp = 0;
      go_sleep_wfe(); chk("R3 wfe enters", outs(), 4'b0100);
      irq = 16'h8001; tick();
      chk("R5 irq ignored w/o sev", outs(), 4'b0100);
      irq = '0; evt = 4'b1000; tick(); evt = '0;
      chk("R5 event wakes", outs(), 4'b1001);
      tick(); chk("R10 evt pulse one cycle", outs(), 4'b1000);
   endtask

   task automatic t_wfe_sev();
      sevp = 1;
      go_sleep_wfe(); chk("R6 wfe enters", outs(), 4'b0100);
      irq = 16'h0020; tick(); irq = '0;
      chk("R6 irq wakes with sev", outs(), 4'b1010);
      tick();
      go_sleep_wfe();
      irq = 16'h0001; evt = 4'b0001; tick(); idle_all();
      chk("R6 irq priority over event", outs(), 4'b1010);
      sevp = 0; tick();
   endtask

   task automatic t_on_exit();
      soe = 1;
      go_sleep_wfi(); chk("R7 wfi ignored", outs(), 4'b1000);
      go_sleep_wfe(); chk("R7 wfe ignored", outs(), 4'b1000);
      excr = 1; irq = 16'h0100; tick(); idle_all();
      chk("R7 exit with pending irq", outs(), 4'b1000);
      excr = 1; tick(); excr = 0;
      chk("R7 exit enters", outs(), 4'b0100);
      evt = 4'b0100; tick(); evt = '0;
      chk("R7 interrupt-wait rule", outs(), 4'b0100);
      irq = 16'h0002; tick(); irq = '0;
      chk("R7 irq wakes", outs(), 4'b1010);
      soe = 0; tick();
   endtask

   task automatic t_cancel();
      wfi = 1; irq = 16'h0004; tick(); idle_all();
      chk("R8 wfi cancelled by irq", outs(), 4'b1000);
      wfe = 1; evt = 4'b0001; tick(); idle_all();
      chk("R8 wfe cancelled by event", outs(), 4'b1000);
      sevp = 1; wfe = 1; irq = 16'h0010; tick(); idle_all();
      chk("R8 wfe cancelled by irq with sev", outs(), 4'b1000);
      sevp = 0; wfe = 1; irq = 16'h0010; tick(); idle_all();
      chk("R8 irq does not cancel wfe w/o sev", outs(), 4'b0100);
      evt = 4'b0001; tick(); evt = '0;
      chk("R8 wake after entry", outs(), 4'b1001);
      tick();
      wfi = 1; wfe = 1; tick(); idle_all();
      chk("R3 both pulses enter", outs(), 4'b0100);
      evt = 4'b1111; tick(); evt = '0;
      chk("R3 both pulses use irq rule", outs(), 4'b0100);
      irq = 16'h0001; tick(); irq = '0;
      chk("R3 both pulses irq wake", outs(), 4'b1010);
      tick();
   endtask

   task automatic t_cause_clear();
      go_sleep_wfe();
      evt = 4'b0010; tick(); evt = '0;
      chk("R9 wfe sleep woken", outs(), 4'b1001);
      tick();
      go_sleep_wfi();
      evt = 4'b0010; tick(); evt = '0;
      chk("R9 cause cleared, event ignored", outs(), 4'b0100);
      irq = 16'h4000; tick(); irq = '0;
      chk("R9 irq wakes", outs(), 4'b1010);
      tick();
   endtask

   initial begin
      fork
         begin
            repeat (3) tick();
            rst_n = 1'b1;
            tick();
            t_reset();
            t_deep();
            t_wfi();
            t_wfe();
            t_wfe_sev();
            t_on_exit();
            t_cancel();
            t_cause_clear();
         end
         begin
            repeat (5000) @(posedge clk);
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule